// File: doc/BRIEF.md
# Two-Input Packet Steering Router

This block takes packets from two input streams and steers each one into one of two output streams. The choice depends on an 8-bit destination field in the packet. The block also keeps a running tally of the packets it has moved that carry an "interesting" flag. Every port is a valid/ready stream. Each output stream sits behind a one-entry holding slot, so a packet leaves its input in the same cycle it is written into that slot, and it appears at the output on the next cycle.

Each input is steered by a separate decision for each destination, so one input never waits on the output it is not heading for. When the two inputs aim at different outputs, both packets move in the same cycle. When they aim at the same output, input 0 wins and input 1 waits. The tally is exposed as a free-running count.

A packet is a 25-bit word laid out as {dest[7:0], flag, payload[15:0]}: bits 24..17 hold the destination, bit 16 holds the interesting flag, and bits 15..0 hold the payload.

Top module: `router_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, both output valids are low and `hit_count` is 0.
- R2: A packet whose destination field (bits 24..17) equals 1 is delivered on output 0. Any other destination value, including 0 and 255, is delivered on output 1. The packet word is delivered unchanged.
- R3: A packet accepted on an input (valid and ready high together) is presented on its output in the next cycle. No packet is lost or duplicated, and each output delivers its packets in the order they were accepted.
- R4: `hit_count` rises by one for each accepted packet whose flag (bit 16) is 1. It rises by 2 when both inputs accept flagged packets in the same cycle, and it wraps modulo 2^16.
- R5: When both inputs are valid and target the same output, `in1_ready` is low, and input 0 moves if that output can take a packet.
- R6: An input's ready depends only on the output that input targets. A stalled output never blocks a packet headed for the other output, and two packets for different outputs move in the same cycle.
- R7: While an output's valid is high and its ready is low, that output keeps its valid high and its data unchanged.
- R8: An output slot takes a new packet in the same cycle that its held packet is taken, so a stream runs at one packet per cycle.
- R9: `in0_ready` is high exactly when the output selected by `in0_data` is empty or has its ready high, whatever input 1 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in0_valid | input | 1 | Input 0 has a packet |
| in0_ready | output | 1 | Input 0 packet is taken this cycle |
| in0_data | input | 25 | Input 0 packet {dest, flag, payload} |
| in1_valid | input | 1 | Input 1 has a packet |
| in1_ready | output | 1 | Input 1 packet is taken this cycle |
| in1_data | input | 25 | Input 1 packet {dest, flag, payload} |
| out0_valid | output | 1 | Output 0 holds a packet (destination 1) |
| out0_ready | input | 1 | Downstream takes output 0 packet |
| out0_data | output | 25 | Output 0 packet |
| out1_valid | output | 1 | Output 1 holds a packet (other destinations) |
| out1_ready | input | 1 | Downstream takes output 1 packet |
| out1_data | output | 25 | Output 1 packet |
| hit_count | output | 16 | Number of flagged packets moved, wrapping |

## Verification
The bench goes after collisions where both inputs name output 0, or both name output 1. A design that arbitrated wrongly there would either let input 1 overwrite input 0 in the slot or drop one of the two packets. It also holds one output stalled while the other runs. A router that gated ready on both outputs would then show `in0_ready` or `in1_ready` low against the model. It drives destinations 0, 1, 2 and 255 to catch a decode that tests a single bit, and it runs more than 32768 cycles of dual flagged moves to force the counter to wrap. A counter that added only one per cycle, or saturated instead of wrapping, would end on the wrong value. It also checks that a slot refills in the same cycle it drains, because a slot that waited for an empty cycle would halve throughput and its ready would disagree with the model.

// File: rtl/router_pkg.sv
package router_pkg;
    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_e;
endpackage

// File: rtl/pkt_classify.sv
module pkt_classify
    import router_pkg::*;
#(
    parameter int DEST_W   = 8,
    parameter int HIT_CODE = 1
) (
    input  logic [DEST_W-1:0] dest,
    input  logic              flag,
    output port_e             port,
    output logic              hot
);
    localparam logic [DEST_W-1:0] MATCH = DEST_W'(HIT_CODE);

    always_comb begin
        port = (dest == MATCH) ? PORT_A : PORT_B;
        hot  = flag;
    end
endmodule

// File: rtl/move_arbiter.sv
module move_arbiter
    import router_pkg::*;
(
    input  logic       v0,
    input  logic       v1,
    input  port_e      p0,
    input  port_e      p1,
    input  logic [1:0] accept,
    output logic       rdy0,
    output logic       rdy1,
    output logic       go0,
    output logic       go1
);
    logic clash;

    always_comb begin
        clash = v0 && (p0 == p1);
        rdy0  = accept[p0];
        rdy1  = accept[p1] && !clash;
        go0   = v0 && rdy0;
        go1   = v1 && rdy1;
    end
endmodule

// File: rtl/out_slot.sv
module out_slot #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         accept
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        accept = !slot_q.valid || out_ready;
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.data  = load_data;
        end else if (out_ready) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign out_valid = slot_q.valid;
    assign out_data  = slot_q.data;
endmodule

// File: rtl/router_top.sv
module router_top
    import router_pkg::*;
#(
    parameter int DEST_W   = 8,
    parameter int PAY_W    = 16,
    parameter int CNT_W    = 16,
    parameter int HIT_CODE = 1,
    localparam int PKT_W   = DEST_W + 1 + PAY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in0_valid,
    output logic             in0_ready,
    input  logic [PKT_W-1:0] in0_data,
    input  logic             in1_valid,
    output logic             in1_ready,
    input  logic [PKT_W-1:0] in1_data,
    output logic             out0_valid,
    input  logic             out0_ready,
    output logic [PKT_W-1:0] out0_data,
    output logic             out1_valid,
    input  logic             out1_ready,
    output logic [PKT_W-1:0] out1_data,
    output logic [CNT_W-1:0] hit_count
);
    localparam int FLAG_BIT = PAY_W;
    localparam int NPORT    = 2;

    logic [PKT_W-1:0] in_data   [NPORT];
    logic [NPORT-1:0] in_valid;
    port_e            in_port   [NPORT];
    logic [NPORT-1:0] in_hot;
    logic [NPORT-1:0] slot_accept;
    logic [NPORT-1:0] slot_ready;
    logic [NPORT-1:0] slot_valid;
    logic [PKT_W-1:0] slot_data [NPORT];
    logic             go0, go1;

    assign in_data[0]    = in0_data;
    assign in_data[1]    = in1_data;
    assign in_valid      = {in1_valid, in0_valid};
    assign slot_ready    = {out1_ready, out0_ready};

    for (genvar i = 0; i < NPORT; i++) begin : g_cls
        pkt_classify #(.DEST_W(DEST_W), .HIT_CODE(HIT_CODE)) u_cls (
            .dest (in_data[i][PKT_W-1 -: DEST_W]),
            .flag (in_data[i][FLAG_BIT]),
            .port (in_port[i]),
            .hot  (in_hot[i])
        );
    end

    move_arbiter u_arb (
        .v0     (in_valid[0]),
        .v1     (in_valid[1]),
        .p0     (in_port[0]),
        .p1     (in_port[1]),
        .accept (slot_accept),
        .rdy0   (in0_ready),
        .rdy1   (in1_ready),
        .go0    (go0),
        .go1    (go1)
    );

    for (genvar k = 0; k < NPORT; k++) begin : g_slot
        logic             take0, take1, load;
        logic [PKT_W-1:0] pick;
        always_comb begin
            take0 = go0 && (in_port[0] == port_e'(k));
            take1 = go1 && (in_port[1] == port_e'(k));
            load  = take0 || take1;
            pick  = take0 ? in_data[0] : in_data[1];
        end
        out_slot #(.W(PKT_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .load_data (pick),
            .out_ready (slot_ready[k]),
            .out_valid (slot_valid[k]),
            .out_data  (slot_data[k]),
            .accept    (slot_accept[k])
        );
    end

    assign out0_valid = slot_valid[0];
    assign out0_data  = slot_data[0];
    assign out1_valid = slot_valid[1];
    assign out1_data  = slot_data[1];

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_t;

    tally_t tally_d, tally_q;

    always_comb begin
        tally_d     = tally_q;
        tally_d.cnt = tally_q.cnt
                    + CNT_W'(go0 && in_hot[0])
                    + CNT_W'(go1 && in_hot[1]);
    end

    always_ff @(posedge clk) begin
        if (rst) tally_q <= '0;
        else     tally_q <= tally_d;
    end

    assign hit_count = tally_q.cnt;
endmodule

// File: rtl/router_props.sv
module router_props #(
    parameter int DEST_W   = 8,
    parameter int PAY_W    = 16,
    parameter int CNT_W    = 16,
    parameter int HIT_CODE = 1,
    localparam int PKT_W   = DEST_W + 1 + PAY_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in0_valid,
    input logic             in0_ready,
    input logic [PKT_W-1:0] in0_data,
    input logic             in1_valid,
    input logic             in1_ready,
    input logic [PKT_W-1:0] in1_data,
    input logic             out0_valid,
    input logic             out0_ready,
    input logic [PKT_W-1:0] out0_data,
    input logic             out1_valid,
    input logic             out1_ready,
    input logic [PKT_W-1:0] out1_data,
    input logic [CNT_W-1:0] hit_count
);
    logic             a0, a1, mv0, mv1;
    logic [CNT_W-1:0] inc;

    always_comb begin
        a0  = in0_data[PKT_W-1 -: DEST_W] == DEST_W'(HIT_CODE);
        a1  = in1_data[PKT_W-1 -: DEST_W] == DEST_W'(HIT_CODE);
        mv0 = in0_valid && in0_ready;
        mv1 = in1_valid && in1_ready;
        inc = CNT_W'(mv0 && in0_data[PAY_W]) + CNT_W'(mv1 && in1_data[PAY_W]);
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> hit_count == $past(hit_count) + $past(inc)); // R4
    AST_SAME_PORT_PRIO: assert property (@(posedge clk) disable iff (rst)
        in0_valid && in1_valid && (a0 == a1) |-> !in1_ready); // R5
    AST_HOLD_OUT0: assert property (@(posedge clk) disable iff (rst)
        out0_valid && !out0_ready |=> out0_valid && $stable(out0_data)); // R7
    AST_HOLD_OUT1: assert property (@(posedge clk) disable iff (rst)
        out1_valid && !out1_ready |=> out1_valid && $stable(out1_data)); // R7
    AST_STEER_IN0_A: assert property (@(posedge clk) disable iff (rst)
        mv0 && a0 |=> out0_valid && out0_data == $past(in0_data)); // R2
    AST_STEER_IN1_B: assert property (@(posedge clk) disable iff (rst)
        mv1 && !a1 |=> out1_valid && out1_data == $past(in1_data)); // R2
    AST_FREE_PATH: assert property (@(posedge clk) disable iff (rst)
        in0_valid && !a0 && (!out1_valid || out1_ready) |-> in0_ready); // R6
endmodule

bind router_top router_props #(
    .DEST_W(DEST_W), .PAY_W(PAY_W), .CNT_W(CNT_W), .HIT_CODE(HIT_CODE)
) u_props (.*);

// File: tb/router_top_test.sv
module router_top_test;
    localparam int PW = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in0_valid = 1'b0, in1_valid = 1'b0;
    logic          in0_ready, in1_ready;
    logic [PW-1:0] in0_data = '0, in1_data = '0;
    logic          out0_valid, out1_valid;
    logic          out0_ready = 1'b0, out1_ready = 1'b0;
    logic [PW-1:0] out0_data, out1_data;
    logic [15:0]   hit_count;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    router_top uut (.*);

    logic [PW-1:0] src0[$], src1[$], sb0[$], sb1[$];
    logic          mv[2];
    logic [PW-1:0] mp[2];
    logic [15:0]   mcnt;
    int            serial = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [PW-1:0] mk(input logic [7:0] d, input logic f);
        serial++;
        return {d, f, 16'(serial)};
    endfunction

    function automatic logic [7:0] pick_dest(input int mode, input int side);
        int r;
        if (mode == 1) return 8'd1;
        if (mode == 2) return side == 0 ? 8'd1 : 8'd7;
        r = int'($urandom % 5);
        case (r)
            0: return 8'd0;
            1: return 8'd1;
            2: return 8'd2;
            3: return 8'd255;
            default: return 8'($urandom);
        endcase
    endfunction

    function automatic int route(input logic [PW-1:0] p);
        return (p[24:17] == 8'd1) ? 0 : 1;
    endfunction

    task automatic run(input int n, input int pv, input int pr0, input int pr1,
                       input int mode, input int pflag);
        for (int c = 0; c < n; c++) begin
            logic acc[2], ordy[2], er0, er1, g0, g1;
            int r0, r1;
            @(negedge clk);
            chk("R3 R8 out0_valid", 32'(out0_valid), 32'(mv[0]));
            if (mv[0]) chk("R2 R7 out0_data", 32'(out0_data), 32'(mp[0]));
            chk("R3 R8 out1_valid", 32'(out1_valid), 32'(mv[1]));
            if (mv[1]) chk("R2 R7 out1_data", 32'(out1_data), 32'(mp[1]));
            chk("R4 hit_count", 32'(hit_count), 32'(mcnt));
            if (src0.size() < 3) src0.push_back(mk(pick_dest(mode, 0), int'($urandom % 100) < pflag));
            if (src1.size() < 3) src1.push_back(mk(pick_dest(mode, 1), int'($urandom % 100) < pflag));
            in0_valid  = (int'($urandom % 100) < pv);
            in1_valid  = (int'($urandom % 100) < pv);
            in0_data   = src0[0];
            in1_data   = src1[0];
            out0_ready = (int'($urandom % 100) < pr0);
            out1_ready = (int'($urandom % 100) < pr1);
            #1;
            ordy[0] = out0_ready;
            ordy[1] = out1_ready;
            for (int k = 0; k < 2; k++) acc[k] = !mv[k] || ordy[k];
            r0  = route(in0_data);
            r1  = route(in1_data);
            er0 = acc[r0];
            er1 = acc[r1] && !(in0_valid && r0 == r1);
            chk("R6 R9 in0_ready", 32'(in0_ready), 32'(er0));
            chk("R5 R6 in1_ready", 32'(in1_ready), 32'(er1));
            g0 = in0_valid && er0;
            g1 = in1_valid && er1;
            for (int k = 0; k < 2; k++) begin
                if (mv[k] && ordy[k]) begin
                    logic [PW-1:0] e;
                    e = (k == 0) ? sb0.pop_front() : sb1.pop_front();
                    chk("R3 order", 32'(mp[k]), 32'(e));
                    mv[k] = 1'b0;
                end
            end
            if (g0) begin
                mv[r0] = 1'b1; mp[r0] = in0_data;
                if (r0 == 0) sb0.push_back(in0_data); else sb1.push_back(in0_data);
                mcnt = mcnt + 16'(in0_data[16]);
                void'(src0.pop_front());
            end
            if (g1) begin
                mv[r1] = 1'b1; mp[r1] = in1_data;
                if (r1 == 0) sb0.push_back(in1_data); else sb1.push_back(in1_data);
                mcnt = mcnt + 16'(in1_data[16]);
                void'(src1.pop_front());
            end
        end
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        mv[0] = 1'b0; mv[1] = 1'b0; mp[0] = '0; mp[1] = '0; mcnt = '0;
        in0_valid = 1'b1;
        in0_data  = {8'd1, 1'b1, 16'hBEEF};
        out0_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset out0_valid", 32'(out0_valid), 32'd0);
        chk("R1 reset out1_valid", 32'(out1_valid), 32'd0);
        chk("R1 reset hit_count", 32'(hit_count), 32'd0);
        in0_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle out0_valid", 32'(out0_valid), 32'd0);
        chk("R1 idle hit_count", 32'(hit_count), 32'd0);
        run(2000, 100, 100, 100, 0, 50);
        run(400, 90, 100, 0, 0, 50);
        run(400, 90, 0, 100, 0, 50);
        run(4000, 60, 50, 50, 0, 50);
        run(1000, 100, 70, 70, 1, 50);
        run(33000, 100, 100, 100, 2, 100);
        run(20, 0, 100, 100, 0, 0);
        chk("R3 drained out0", 32'(sb0.size()), 32'd0);
        chk("R3 drained out1", 32'(sb1.size()), 32'd0);
        chk("R4 final count", 32'(hit_count), 32'(mcnt));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule